// File: doc/BRIEF.md
# Interrupt and Reset Vector Sequencer

This block decides when a small 8-bit processor core must abandon its normal instruction flow and where it must go next. It watches the active-low reset, non-maskable and maskable interrupt lines. When one of them wins arbitration, it reads a two-byte vector from the top of a 16-bit address space, low byte first, and hands the assembled program counter to the core with a one-clock valid pulse.

Reset has the highest priority. The fetch starts only once the reset line has returned high. A non-maskable request is caught on its falling edge and held pending until an instruction boundary. A maskable request is a level that counts only when the boundary strobe is high and the interrupt-disable flag is clear. Every vector cycle is a bus read. A low wait input stretches that read, and the address stays the same until the input returns high. Stack pushes, instruction decode and the arithmetic unit belong to the core.

Top module: `vector_sequencer`

## Requirements
- R1: While `res_n` is low no fetch runs (`fetch_active`=0, `pc_valid`=0, `vec_addr`=0000). On the first clock with `res_n` high the sequencer reads FFFC (low byte) and then FFFD (high byte), with no instruction boundary required.
- R2: A high-to-low transition of `nmi_n` sets a pending request. The request is served at the next clock with `insn_done`=1 by reading FFFA (low) and FFFB (high). It is never served while `insn_done` stays 0.
- R3: The pending non-maskable request clears when its fetch begins, so `nmi_n` held low gives exactly one fetch.
- R4: With `irq_n` low, `irq_disable`=0 and `insn_done`=1 on a clock edge in the idle state, the sequencer reads FFFE (low) and then FFFF (high).
- R5: With `irq_disable`=1 a low `irq_n` starts no fetch.
- R6: `irq_n` is sampled only on clocks with `insn_done`=1. A low pulse that has ended before such a clock starts no fetch.
- R7: Reset has priority over a pending non-maskable request, and a pending non-maskable request has priority over a maskable one at the same boundary. The losing request is served afterwards.
- R8: A vector read cycle with `rdy`=0 is repeated on the next clock at the same `vec_addr`, and `fetch_active` stays 1.
- R9: A fetch occupies two read cycles with `fetch_active`=1. The first drives the even vector address and takes the low byte from `rd_data`. The second drives the odd address and takes the high byte.
- R10: One clock after the high byte is accepted, `pc_valid` is 1 for exactly one clock. In that clock `new_pc` equals {high byte, low byte} and `fetch_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| res_n | input | 1 | Active-low processor reset, sampled on the clock |
| nmi_n | input | 1 | Active-low non-maskable request, edge sensitive |
| irq_n | input | 1 | Active-low maskable request, level sensitive |
| irq_disable | input | 1 | Interrupt-disable status flag (status bit 2) |
| insn_done | input | 1 | High on the last clock of an instruction |
| rdy | input | 1 | Wait input; low stretches the current read cycle |
| rd_data | input | 8 | Read data bus |
| vec_addr | output | 16 | Vector address during a fetch, 0000 otherwise |
| fetch_active | output | 1 | High while a vector read cycle is on the bus |
| new_pc | output | 16 | Assembled program counter |
| pc_valid | output | 1 | One-clock strobe marking `new_pc` as loaded |

## Verification
The assertions assume that `insn_done` is low throughout a vector fetch, because the core is stalled then, and that `rd_data` is valid on every clock where `rdy` is high during a fetch. The bench changes every input only on the falling clock edge, so no input changes in the middle of a sample. It keeps `insn_done` low while a fetch is in progress. It raises `nmi_n` between non-maskable tests, so each test starts from a clean high-to-low transition.

// File: rtl/vseq_pkg.sv
package vseq_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI} fetch_st_e;
    typedef enum logic [1:0] {SRC_RST, SRC_NMI, SRC_IRQ} req_src_e;

    localparam logic [ADDR_W-1:0] VEC_NMI = 16'hFFFA;
    localparam logic [ADDR_W-1:0] VEC_RST = 16'hFFFC;
    localparam logic [ADDR_W-1:0] VEC_IRQ = 16'hFFFE;

    function automatic logic [ADDR_W-1:0] vec_base(req_src_e s);
        case (s)
            SRC_RST: return VEC_RST;
            SRC_NMI: return VEC_NMI;
            default: return VEC_IRQ;
        endcase
    endfunction
endpackage

// File: rtl/req_capture.sv
module req_capture (
    input  logic clk,
    input  logic res_n,
    input  logic nmi_n,
    input  logic irq_n,
    input  logic irq_disable,
    input  logic insn_done,
    input  logic take_nmi,
    output logic nmi_pend,
    output logic irq_req
);
    typedef struct packed {
        logic nmi_prev;
        logic pend;
    } cap_t;

    cap_t cap_d, cap_q;
    logic nmi_fall;

    always_comb begin
        cap_d          = cap_q;
        cap_d.nmi_prev = nmi_n;
        nmi_fall       = cap_q.nmi_prev & ~nmi_n;
        cap_d.pend     = nmi_fall | (cap_q.pend & ~take_nmi);
        irq_req        = insn_done & ~irq_n & ~irq_disable;
    end

    always_ff @(posedge clk) begin
        if (!res_n) begin
            cap_q.nmi_prev <= 1'b1;
            cap_q.pend     <= 1'b0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign nmi_pend = cap_q.pend;

    // R2
    nmi_edge_latched_chk: assert property (@(posedge clk) disable iff (!res_n)
        $fell(nmi_n) |=> nmi_pend);

    // R5
    irq_masked_chk: assert property (@(posedge clk) disable iff (!res_n)
        irq_disable |-> !irq_req);
endmodule

// File: rtl/vector_fetch.sv
module vector_fetch
    import vseq_pkg::*;
(
    input  logic              clk,
    input  logic              res_n,
    input  logic              nmi_pend,
    input  logic              irq_req,
    input  logic              insn_done,
    input  logic              rdy,
    input  logic [DATA_W-1:0] rd_data,
    output logic              take_nmi,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              fetch_active,
    output logic [ADDR_W-1:0] new_pc,
    output logic              pc_valid
);
    typedef struct packed {
        fetch_st_e         st;
        req_src_e          src;
        logic [DATA_W-1:0] lo;
        logic [ADDR_W-1:0] pc;
        logic              valid;
        logic              rst_pend;
    } fsm_t;

    fsm_t f_d, f_q;
    logic [ADDR_W-1:0] base;

    always_comb begin
        f_d       = f_q;
        f_d.valid = 1'b0;
        take_nmi  = 1'b0;
        case (f_q.st)
            ST_IDLE: begin
                if (f_q.rst_pend) begin
                    f_d.st       = ST_LO;
                    f_d.src      = SRC_RST;
                    f_d.rst_pend = 1'b0;
                end else if (insn_done && nmi_pend) begin
                    f_d.st   = ST_LO;
                    f_d.src  = SRC_NMI;
                    take_nmi = 1'b1;
                end else if (irq_req) begin
                    f_d.st  = ST_LO;
                    f_d.src = SRC_IRQ;
                end
            end
            ST_LO: begin
                if (rdy) begin
                    f_d.lo = rd_data;
                    f_d.st = ST_HI;
                end
            end
            ST_HI: begin
                if (rdy) begin
                    f_d.pc    = {rd_data, f_q.lo};
                    f_d.valid = 1'b1;
                    f_d.st    = ST_IDLE;
                end
            end
            default: f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!res_n) begin
            f_q.st       <= ST_IDLE;
            f_q.src      <= SRC_RST;
            f_q.lo       <= '0;
            f_q.pc       <= '0;
            f_q.valid    <= 1'b0;
            f_q.rst_pend <= 1'b1;
        end else begin
            f_q <= f_d;
        end
    end

    assign base         = vec_base(f_q.src);
    assign fetch_active = (f_q.st != ST_IDLE);
    assign vec_addr     = fetch_active ? {base[ADDR_W-1:1], (f_q.st == ST_HI)} : '0;
    assign new_pc       = f_q.pc;
    assign pc_valid     = f_q.valid;

    // R8
    rdy_stall_chk: assert property (@(posedge clk) disable iff (!res_n)
        (fetch_active && !rdy) |=> (fetch_active && $stable(vec_addr)));

    // R10
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!res_n)
        pc_valid |=> !pc_valid);

    // R9
    vec_range_chk: assert property (@(posedge clk) disable iff (!res_n)
        fetch_active |-> (vec_addr[ADDR_W-1:3] == '1 && vec_addr[2:1] != 2'b00));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!res_n)
        (!fetch_active && !insn_done && !f_q.rst_pend) |=> !fetch_active);

    // R10
    valid_after_fetch_chk: assert property (@(posedge clk) disable iff (!res_n)
        pc_valid |-> !fetch_active);
endmodule

// File: rtl/vector_sequencer.sv
module vector_sequencer
    import vseq_pkg::*;
(
    input  logic              clk,
    input  logic              res_n,
    input  logic              nmi_n,
    input  logic              irq_n,
    input  logic              irq_disable,
    input  logic              insn_done,
    input  logic              rdy,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              fetch_active,
    output logic [ADDR_W-1:0] new_pc,
    output logic              pc_valid
);
    logic take_nmi;
    logic nmi_pend;
    logic irq_req;

    req_capture i_capture (
        .clk         (clk),
        .res_n       (res_n),
        .nmi_n       (nmi_n),
        .irq_n       (irq_n),
        .irq_disable (irq_disable),
        .insn_done   (insn_done),
        .take_nmi    (take_nmi),
        .nmi_pend    (nmi_pend),
        .irq_req     (irq_req)
    );

    vector_fetch i_fetch (
        .clk          (clk),
        .res_n        (res_n),
        .nmi_pend     (nmi_pend),
        .irq_req      (irq_req),
        .insn_done    (insn_done),
        .rdy          (rdy),
        .rd_data      (rd_data),
        .take_nmi     (take_nmi),
        .vec_addr     (vec_addr),
        .fetch_active (fetch_active),
        .new_pc       (new_pc),
        .pc_valid     (pc_valid)
    );

    // R3
    nmi_once_chk: assert property (@(posedge clk) disable iff (!res_n)
        (take_nmi && nmi_n) |=> !nmi_pend);
endmodule

// File: tb/test_vector_sequencer.sv
module test_vector_sequencer;
    logic        clk = 1'b0;
    logic        res_n = 1'b0;
    logic        nmi_n = 1'b1;
    logic        irq_n = 1'b1;
    logic        irq_disable = 1'b1;
    logic        insn_done = 1'b0;
    logic        rdy = 1'b1;
    logic [7:0]  rd_data = 8'h00;
    logic [15:0] vec_addr;
    logic        fetch_active;
    logic [15:0] new_pc;
    logic        pc_valid;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vector_sequencer i_vector_sequencer (
        .clk(clk), .res_n(res_n), .nmi_n(nmi_n), .irq_n(irq_n),
        .irq_disable(irq_disable), .insn_done(insn_done), .rdy(rdy),
        .rd_data(rd_data), .vec_addr(vec_addr), .fetch_active(fetch_active),
        .new_pc(new_pc), .pc_valid(pc_valid)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= 20000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_idle(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            check(req, {31'd0, fetch_active}, 32'd0);
        end
    endtask

    // Called on the falling edge right after the clock that started a fetch.
    task automatic run_fetch(input string req, input logic [15:0] base,
                             input logic [7:0] lo, input logic [7:0] hi,
                             input int stall_lo, input int stall_hi);
        check({req, " R9 low cycle"}, {15'd0, fetch_active, vec_addr}, {16'd1, base});
        for (int i = 0; i < stall_lo; i++) begin
            rdy = 1'b0; rd_data = 8'hEE;
            tick();
            check("R8 stalled low read", {15'd0, fetch_active, vec_addr}, {16'd1, base});
        end
        rdy = 1'b1; rd_data = lo;
        tick();
        check({req, " R9 high cycle"}, {15'd0, fetch_active, vec_addr}, {16'd1, base | 16'h0001});
        for (int i = 0; i < stall_hi; i++) begin
            rdy = 1'b0; rd_data = 8'h11;
            tick();
            check("R8 stalled high read", {15'd0, fetch_active, vec_addr}, {16'd1, base | 16'h0001});
        end
        rdy = 1'b1; rd_data = hi;
        tick();
        rd_data = 8'h00;
        check({req, " R10 pc load"}, {14'd0, pc_valid, fetch_active, new_pc}, {16'h0002, hi, lo});
        tick();
        check("R10 single pulse", {31'd0, pc_valid}, 32'd0);
    endtask

    task automatic t_reset();
        res_n = 1'b0;
        tick();
        check("R1 reset idle", {14'd0, fetch_active, pc_valid, vec_addr}, 32'd0);
        expect_idle("R1 no fetch while low", 4);
        res_n = 1'b1;
        tick();
        run_fetch("R1", 16'hFFFC, 8'h34, 8'hE2, 0, 0);
        expect_idle("R1 done", 2);
    endtask

    task automatic t_reset_over_nmi();
        res_n = 1'b0; nmi_n = 1'b1;
        tick(); tick();
        res_n = 1'b1; nmi_n = 1'b0;
        tick();
        run_fetch("R7 reset first", 16'hFFFC, 8'h00, 8'hC0, 0, 1);
        insn_done = 1'b1;
        tick();
        insn_done = 1'b0;
        run_fetch("R7 nmi after reset", 16'hFFFA, 8'h43, 8'hFE, 0, 0);
        insn_done = 1'b1;
        expect_idle("R3 held nmi once", 3);
        insn_done = 1'b0;
        nmi_n = 1'b1;
        tick();
    endtask

    task automatic t_nmi_boundary();
        nmi_n = 1'b0;
        expect_idle("R2 wait for boundary", 4);
        nmi_n = 1'b1;
        tick();
        insn_done = 1'b1;
        tick();
        insn_done = 1'b0;
        run_fetch("R2", 16'hFFFA, 8'h5A, 8'hA5, 2, 1);
    endtask

    task automatic t_irq_pulse();
        irq_disable = 1'b0;
        irq_n = 1'b0;
        expect_idle("R6 level off boundary", 3);
        irq_n = 1'b1;
        tick();
        insn_done = 1'b1;
        expect_idle("R6 pulse gone", 2);
        insn_done = 1'b0;
    endtask

    task automatic t_irq_masked();
        irq_disable = 1'b1; irq_n = 1'b0; insn_done = 1'b1;
        expect_idle("R5 masked", 3);
        irq_disable = 1'b0;
        tick();
        insn_done = 1'b0;
        run_fetch("R4", 16'hFFFE, 8'h48, 8'hFF, 1, 2);
        irq_n = 1'b1;
        tick();
    endtask

    task automatic t_nmi_over_irq();
        irq_disable = 1'b0;
        nmi_n = 1'b0; irq_n = 1'b0;
        tick();
        insn_done = 1'b1;
        tick();
        insn_done = 1'b0;
        run_fetch("R7 nmi before irq", 16'hFFFA, 8'h10, 8'h20, 0, 0);
        insn_done = 1'b1;
        tick();
        insn_done = 1'b0;
        run_fetch("R7 irq after nmi", 16'hFFFE, 8'h30, 8'h40, 0, 0);
        irq_n = 1'b1; nmi_n = 1'b1;
        tick();
    endtask

    initial begin
        t_reset();
        t_reset_over_nmi();
        t_nmi_boundary();
        t_irq_pulse();
        t_irq_masked();
        t_nmi_over_irq();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule